// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block guards a processor against a stalled program. A counter advances on every pulse of a low-speed tick, which the clock unit derives from the 32.768 kHz clock. The counter always runs, and software has no way to stop it. Software proves it is alive by writing a two-byte key to the key register before the selected period runs out.

A missed period is handled in two steps. The first overflow raises a non-maskable interrupt request, which gives a handler one more period to recover. If a second overflow follows with no service in between, the block raises a reset request. That request stays high until the chip's reset generator applies system reset. A sticky cause flag survives that system reset, so boot code can see why the chip restarted. Only the power-on reset or a write of 1 from software clears the flag.

Writes arrive on a plain single-cycle register port. There is no back-pressure: every write with `wr_en` high takes effect at that clock edge. The request outputs and the cause flag are plain levels.

Top module: `wdt_guard`

## Requirements
- R1: After system reset, `nmi_req` and `rst_req` are 0, the count is zero and the period select is 0.
- R2: The period is 2^(BASE_LOG2 + 2*sel) ticks for a 2-bit select `sel`. With the default BASE_LOG2 of 12, this gives 4096, 16384, 65536 and 262144 ticks, which is 125 ms, 500 ms, 2 s and 8 s at 32.768 kHz. `nmi_req` rises exactly after that many ticks, counted from reset or from the last clear.
- R3: `nmi_req` stays high until a clear. A second overflow that follows with no clear in between raises `rst_req`, and `rst_req` is never raised while `nmi_req` is low.
- R4: Once raised, `rst_req` stays high through any further ticks and clears, until system reset.
- R5: A clear is a write of 0x5A to address 0 followed later by a write of 0xA5 to address 0. It zeroes the count, drops `nmi_req` and cancels the escalation.
- R6: On address 0, a value other than 0x5A or 0xA5 disarms the sequence. So does 0xA5 when the block is not armed. Writing 0x5A always re-arms it. Writes to other addresses between the two keys leave the sequence intact.
- R7: Writing address 1 sets the select from data bits [1:0], but only until the first clear after system reset. From then on, writes to address 1 are ignored.
- R8: The count can never be stopped or restarted except by a full key pair. Writes to addresses 1, 2 and 3, and a lone 0x5A, leave the overflow time unchanged.
- R9: `wdt_cause` goes to 1 one cycle after `rst_req` is high. It survives system reset. `por_n` clears it, and so does a write to address 2 with data bit 0 set. A write to address 2 with bit 0 clear has no effect.
- R10: If the second key arrives in the same cycle as the tick that would overflow, the clear wins: no request is raised and the count restarts from zero.
- R11: The count advances only in cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the cause flag |
| rst_n | input | 1 | System reset, active low; the cause flag is kept |
| tick | input | 1 | One-cycle enable per low-speed clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 key, 1 period select, 2 status, 3 unused |
| wr_data | input | 8 | Write data |
| nmi_req | output | 1 | Non-maskable interrupt request level |
| rst_req | output | 1 | System reset request level |
| wdt_cause | output | 1 | Sticky flag: the last reset request came from this block |

## Verification
The hardest case to reach is a key completion that lands on the very tick that would overflow. To get there, the stimulus counts exactly one tick short of the period, writes the arm key, and then drives the fire key and the tick in the same cycle. It also checks that the count restarts from zero afterwards. The other hard case is the cause flag surviving a system reset. The bench lets a full two-stage escalation run, pulses only the system reset, and then checks the flag through its write-one-to-clear and power-on paths.

// File: rtl/wdt_guard_pkg.sv
`timescale 1ns/1ps
package wdt_guard_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_KEY    = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;
  localparam logic [DATA_W-1:0] KEY_ARM  = 8'h5A;
  localparam logic [DATA_W-1:0] KEY_FIRE = 8'hA5;
endpackage

// File: rtl/wdt_keyseq.sv
`timescale 1ns/1ps
module wdt_keyseq
  import wdt_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              clr
);
  logic armed;
  logic key_wr;

  assign key_wr = wr_en && (wr_addr == ADDR_KEY);
  assign clr    = key_wr && armed && (wr_data == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (key_wr) begin
      armed <= (wr_data == KEY_ARM);
    end
  end

  // R6
  other_addr_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR_KEY) |=> $stable(armed));
endmodule

// File: rtl/wdt_timebase.sv
`timescale 1ns/1ps
module wdt_timebase #(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             ovf
);
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int CW      = BASE_LOG2 + STEP_LOG2 * (NUM_SEL - 1);

  logic [CW-1:0] lim_tbl [NUM_SEL];
  logic [CW-1:0] cnt;
  logic          wrap;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign lim_tbl[g] = ~({CW{1'b1}} << (BASE_LOG2 + STEP_LOG2 * g));
  end

  assign wrap = tick && (cnt >= lim_tbl[sel]);
  assign ovf  = wrap && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));
endmodule

// File: rtl/wdt_escalate.sv
`timescale 1ns/1ps
module wdt_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ovf,
  output logic nmi_req,
  output logic rst_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_req <= 1'b0;
      rst_req <= 1'b0;
    end else if (clr) begin
      nmi_req <= 1'b0;
    end else if (ovf) begin
      if (nmi_req) rst_req <= 1'b1;
      else         nmi_req <= 1'b1;
    end
  end

  // R3
  rst_after_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(nmi_req));
  // R4
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  // R5
  nmi_drop_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_req) |-> $past(clr));
endmodule

// File: rtl/wdt_cause.sv
`timescale 1ns/1ps
module wdt_cause (
  input  logic clk,
  input  logic por_n,
  input  logic rst_req,
  input  logic clr_w1,
  output logic flag
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag <= 1'b0;
    end else if (rst_req) begin
      flag <= 1'b1;
    end else if (clr_w1) begin
      flag <= 1'b0;
    end
  end

  // R9
  cause_source_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flag) |-> $past(rst_req));
endmodule

// File: rtl/wdt_guard.sv
`timescale 1ns/1ps
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int STEP_LOG2 = 2,
  parameter int SEL_W     = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              nmi_req,
  output logic              rst_req,
  output logic              wdt_cause
);
  logic             sys_n;
  logic             clr;
  logic             ovf;
  logic             locked;
  logic [SEL_W-1:0] sel;
  logic             clr_w1;

  assign sys_n  = rst_n && por_n;
  assign clr_w1 = wr_en && (wr_addr == ADDR_STATUS) && wr_data[0];

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      sel    <= '0;
      locked <= 1'b0;
    end else begin
      if (clr) locked <= 1'b1;
      if (wr_en && (wr_addr == ADDR_PERIOD) && !locked)
        sel <= wr_data[SEL_W-1:0];
    end
  end

  // R7
  period_lock_chk: assert property (@(posedge clk) disable iff (!sys_n)
    locked |=> $stable(sel));

  wdt_keyseq u_key (
    .clk(clk), .rst_n(sys_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clr(clr)
  );

  wdt_timebase #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .SEL_W(SEL_W)) u_tb (
    .clk(clk), .rst_n(sys_n), .tick(tick), .clr(clr), .sel(sel), .ovf(ovf)
  );

  wdt_escalate u_esc (
    .clk(clk), .rst_n(sys_n), .clr(clr), .ovf(ovf),
    .nmi_req(nmi_req), .rst_req(rst_req)
  );

  wdt_cause u_cause (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .clr_w1(clr_w1), .flag(wdt_cause)
  );
endmodule

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;
  import wdt_guard_pkg::*;

  localparam int BASE = 3;
  localparam int NV = 4;
  localparam int unsigned VEC_SEL [NV] = '{2, 0, 3, 1};
  localparam int unsigned VEC_PER [NV] = '{128, 8, 512, 32};

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic nmi_req, rst_req, wdt_cause;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_guard #(.BASE_LOG2(BASE)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .nmi_req(nmi_req),
    .rst_req(rst_req), .wdt_cause(wdt_cause)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic service();
    wr(ADDR_KEY, KEY_ARM);
    wr(ADDR_KEY, KEY_FIRE);
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    por_n = 1'b1; rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 nmi_req", nmi_req, 0);
    check("R1 rst_req", rst_req, 0);
    check("R9 cause after por", wdt_cause, 0);

    // R2 R3 table of periods
    for (int v = 0; v < NV; v++) begin
      sys_reset();
      wr(ADDR_PERIOD, DATA_W'(VEC_SEL[v]));
      ticks(VEC_PER[v] - 1);
      check("R2 nmi before period", nmi_req, 0);
      ticks(1);
      check("R2 nmi at period", nmi_req, 1);
      ticks(VEC_PER[v] - 1);
      check("R3 rst before 2nd period", rst_req, 0);
      check("R3 nmi held", nmi_req, 1);
      ticks(1);
      check("R3 rst at 2nd period", rst_req, 1);
    end

    // R4 sticky reset request, R9 cause
    service();
    ticks(20);
    check("R4 rst_req held", rst_req, 1);
    check("R9 cause set", wdt_cause, 1);
    sys_reset();
    check("R4 rst_req cleared by reset", rst_req, 0);
    check("R1 nmi after reset", nmi_req, 0);
    check("R9 cause survives sys reset", wdt_cause, 1);
    wr(ADDR_STATUS, 8'hFE);
    check("R9 write 0 ignored", wdt_cause, 1);
    wr(ADDR_STATUS, 8'h01);
    check("R9 write 1 clears", wdt_cause, 0);

    // R5 clear restarts count and drops nmi (sel 0, period 8)
    sys_reset();
    ticks(7);
    service();
    ticks(7);
    check("R5 no nmi after clear", nmi_req, 0);
    ticks(1);
    check("R5 nmi after full period", nmi_req, 1);
    service();
    check("R5 nmi dropped by clear", nmi_req, 0);
    ticks(8);
    check("R3 fresh nmi not reset", rst_req, 0);

    // R6 wrong sequences do not clear
    sys_reset();
    ticks(4);
    wr(ADDR_KEY, KEY_ARM); wr(ADDR_KEY, 8'h33); wr(ADDR_KEY, KEY_FIRE);
    wr(ADDR_KEY, KEY_FIRE);
    ticks(4);
    check("R6 bad order no clear", nmi_req, 1);
    // R6 other address between keys, repeated arm
    sys_reset();
    ticks(6);
    wr(ADDR_KEY, KEY_ARM); wr(2'd3, 8'hFF); wr(ADDR_KEY, KEY_ARM); wr(ADDR_KEY, KEY_FIRE);
    ticks(7);
    check("R6 clear across other writes", nmi_req, 0);
    ticks(1);
    check("R6 nmi after cleared period", nmi_req, 1);

    // R7 period locked after first clear
    sys_reset();
    service();
    wr(ADDR_PERIOD, 8'h03);
    ticks(8);
    check("R7 locked select ignored", nmi_req, 1);

    // R8 other writes do not restart
    sys_reset();
    ticks(4);
    wr(2'd3, 8'hFF); wr(ADDR_STATUS, 8'h00); wr(ADDR_PERIOD, 8'h00); wr(ADDR_KEY, KEY_ARM);
    ticks(4);
    check("R8 count not restarted", nmi_req, 1);

    // R11 idle cycles not counted
    sys_reset();
    ticks(7);
    idle(40);
    check("R11 idle no nmi", nmi_req, 0);
    ticks(1);
    check("R11 tick completes period", nmi_req, 1);

    // R10 clear on the overflowing tick
    sys_reset();
    ticks(7);
    wr(ADDR_KEY, KEY_ARM);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = ADDR_KEY; wr_data = KEY_FIRE;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R10 clear wins", nmi_req, 0);
    ticks(7);
    check("R10 count restarted", nmi_req, 0);
    ticks(1);
    check("R10 nmi after new period", nmi_req, 1);

    // R9 por clears the cause flag
    ticks(8);
    idle(1);
    check("R9 cause set again", wdt_cause, 1);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    check("R9 por clears cause", wdt_cause, 0);
    check("R1 rst_req after por", rst_req, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule